// File: doc/BRIEF.md
# Majority-sampling serial receiver

This block receives asynchronous serial characters from a single input line. It works from a sampling tick that runs at sixteen times the bit rate. A falling edge on an idle line starts a character. Every bit, the start bit included, is then decided from three samples taken around the middle of the bit, and a 2-of-3 majority gives its value. When the three samples disagree, the character is marked as noisy.

After a complete character (start, eight data bits LSB first, one stop bit), the block loads a data register and raises a data-ready flag. It also reports the character's conditions: overrun when an unread character is overwritten, noise, a bad stop bit, and a line break (a bad stop bit with all-zero data). An idle-line flag marks a quiet line after the last character.

Software reads data through a read strobe, which clears the per-character flags. A separate status-read strobe clears the idle flag. A single interrupt output combines data-ready and idle, each under its own enable. Baud-rate generation and bus decoding are done outside the block.

Top module: `maj_uart_rx`

## Requirements
- R1: Tick numbering restarts at 0 on the tick where the synchronised line is first seen low. Every bit is sampled on ticks 7, 8 and 9 of its 16-tick period, and its value is the majority of those three samples. A sample outside that window does not change the bit.
- R2: `noise` is set for a character when the three samples of any of its bits (start, data or stop) are not all equal. A glitch outside ticks 7 to 9 does not set it.
- R3: A frame is a 0 start bit, eight data bits LSB first and one stop bit. When the stop bit has been voted, `rx_data` holds the eight data bits with the first one received in bit 0, and `rdrf` is set.
- R4: A one-cycle `data_rd` pulse clears `rdrf`, `ovr`, `noise`, `ferr` and `brk` at the next clock edge. `rx_data` keeps its value.
- R5: If the start bit votes 1, the character is dropped and no flag changes. The receiver then waits for the next falling edge.
- R6: When a character completes while `rdrf` is still set, `ovr` is set and `rx_data` takes the new character.
- R7: `idle` sets once 160 consecutive high sampling ticks (one character time) have passed since the last completed character. It sets at most once per received character and is cleared by a one-cycle `stat_rd` pulse.
- R8: `ferr` is set when the stop bit votes 0. `brk` is set together with it when the data bits are all zero.
- R9: While `rx_en` is low, the line is ignored, no character completes, and any character in progress is abandoned.
- R10: `irq` equals (`rie` and `rdrf`) or (`ilie` and `idle`), registered, so it follows a change of an enable or a flag by one clock.
- R11: After reset, all flags, `irq` and `rx_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable |
| rxd | input | 1 | Serial input line, idle high |
| os_tick | input | 1 | One-clock pulse at 16x the bit rate |
| data_rd | input | 1 | Data-register read strobe |
| stat_rd | input | 1 | Status read strobe, clears the idle flag |
| rie | input | 1 | Interrupt enable for data ready |
| ilie | input | 1 | Interrupt enable for idle line |
| rx_data | output | 8 | Last received character |
| rdrf | output | 1 | Data ready |
| idle | output | 1 | Idle line detected |
| ovr | output | 1 | Overrun |
| noise | output | 1 | Noise seen in the last character |
| ferr | output | 1 | Framing error (stop bit voted 0) |
| brk | output | 1 | Break detected |
| irq | output | 1 | Interrupt request |

## Verification
The line passes through two synchroniser flops, so a value driven just before tick k is voted on tick k+1. The vote is registered in the clock after tick 9 of a bit. The completion pulse follows one clock later, and the status flags one clock after that, so they appear three clocks after the stop bit's middle tick. `irq` follows its inputs by one clock, and both read strobes take effect at the next edge.

The bench samples only on falling clock edges. It checks frame results after the stop bit's sixteen ticks and a high gap have gone by, and checks strobe and enable effects on the next falling edge. The idle flag is probed 146 high ticks after completion (expected clear) and again at 176 (expected set), which brackets the 160-tick threshold with margin.

// File: rtl/maj_rx_pkg.sv
package maj_rx_pkg;

  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_t;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import maj_rx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic restart,
  input  logic active,
  output logic vote_stb,
  output logic vote,
  output logic noisy
);

  localparam int CW    = $clog2(OVERSAMPLE);
  localparam int MID   = OVERSAMPLE / 2;
  localparam int FIRST = MID - 1;
  localparam int LAST  = MID + 1;

  logic [CW-1:0] cnt;
  logic          s_a;
  logic          s_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      s_a      <= 1'b0;
      s_b      <= 1'b0;
      vote_stb <= 1'b0;
      vote     <= 1'b0;
      noisy    <= 1'b0;
    end else begin
      vote_stb <= 1'b0;
      if (tick) begin
        if (restart) begin
          cnt <= CW'(1);
        end else if (active) begin
          cnt <= (cnt == CW'(OVERSAMPLE - 1)) ? '0 : cnt + 1'b1;
          if (cnt == CW'(FIRST)) s_a <= line;
          if (cnt == CW'(MID))   s_b <= line;
          if (cnt == CW'(LAST)) begin
            vote_stb <= 1'b1;
            vote     <= maj3(s_a, s_b, line);
            noisy    <= !((s_a == s_b) && (s_b == line));
          end
        end
      end
    end
  end

  // R1
  vote_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    vote_stb |-> $past(tick));

  // R1
  vote_only_active_chk: assert property (@(posedge clk) disable iff (rst)
    vote_stb |-> $past(active));

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
  import maj_rx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  input  logic                 en,
  input  logic                 vote_stb,
  input  logic                 vote,
  input  logic                 noisy,
  output logic                 restart,
  output logic                 active,
  output logic                 hunting,
  output logic                 done,
  output logic [DATA_BITS-1:0] data_out,
  output logic                 frame_noise,
  output logic                 stop_bad,
  output logic                 is_break
);

  localparam int IW = $clog2(DATA_BITS);

  rx_state_t            state;
  logic                 prev;
  logic [IW-1:0]        idx;
  logic [DATA_BITS-1:0] shreg;
  logic                 nacc;

  assign hunting = (state == ST_HUNT);
  assign active  = !hunting;
  assign restart = tick & prev & !line & hunting & en;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_HUNT;
      prev        <= 1'b1;
      idx         <= '0;
      shreg       <= '0;
      nacc        <= 1'b0;
      done        <= 1'b0;
      data_out    <= '0;
      frame_noise <= 1'b0;
      stop_bad    <= 1'b0;
      is_break    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (tick) prev <= line;
      if (!en) begin
        state <= ST_HUNT;
      end else begin
        case (state)
          ST_HUNT: begin
            if (restart) begin
              state <= ST_START;
              nacc  <= 1'b0;
            end
          end
          ST_START: begin
            if (vote_stb) begin
              if (vote) begin
                state <= ST_HUNT;
              end else begin
                state <= ST_DATA;
                idx   <= '0;
                nacc  <= noisy;
              end
            end
          end
          ST_DATA: begin
            if (vote_stb) begin
              shreg <= {vote, shreg[DATA_BITS-1:1]};
              nacc  <= nacc | noisy;
              if (idx == IW'(DATA_BITS - 1)) state <= ST_STOP;
              else idx <= idx + 1'b1;
            end
          end
          ST_STOP: begin
            if (vote_stb) begin
              state       <= ST_HUNT;
              done        <= 1'b1;
              data_out    <= shreg;
              frame_noise <= nacc | noisy;
              stop_bad    <= !vote;
              is_break    <= !vote && (shreg == '0);
            end
          end
          default: state <= ST_HUNT;
        endcase
      end
    end
  end

  // R9
  done_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(en));

  // R3
  done_after_vote_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(vote_stb));

endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer #(
  parameter int LIMIT = 160
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic hunting,
  input  logic arm,
  input  logic disarm,
  output logic fire
);

  localparam int CW = $clog2(LIMIT);

  logic [CW-1:0] cnt;
  logic          armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (disarm) begin
        armed <= 1'b0;
        cnt   <= '0;
      end else if (arm) begin
        armed <= 1'b1;
        cnt   <= '0;
      end else if (tick && armed && hunting) begin
        if (!line) begin
          cnt <= '0;
        end else if (cnt == CW'(LIMIT - 1)) begin
          fire  <= 1'b1;
          armed <= 1'b0;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R7
  fire_when_armed_chk: assert property (@(posedge clk) disable iff (rst)
    fire |-> $past(armed) && $past(hunting));

endmodule

// File: rtl/maj_uart_rx.sv
module maj_uart_rx #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rx_en,
  input  logic                 rxd,
  input  logic                 os_tick,
  input  logic                 data_rd,
  input  logic                 stat_rd,
  input  logic                 rie,
  input  logic                 ilie,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rdrf,
  output logic                 idle,
  output logic                 ovr,
  output logic                 noise,
  output logic                 ferr,
  output logic                 brk,
  output logic                 irq
);

  localparam int IDLE_TICKS = OVERSAMPLE * (DATA_BITS + 2);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   line;

  generate
    if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= rxd;
      end
    end else begin : g_sync_chain
      always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
      end
    end
  endgenerate

  assign line = sync_q[SYNC_STAGES-1];

  logic                 restart, active, hunting;
  logic                 vote_stb, vote, noisy;
  logic                 frame_done, f_noise, f_stop_bad, f_break;
  logic [DATA_BITS-1:0] f_data;
  logic                 idle_fire;

  rx_bit_sampler #(.OVERSAMPLE(OVERSAMPLE)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .tick     (os_tick),
    .line     (line),
    .restart  (restart),
    .active   (active),
    .vote_stb (vote_stb),
    .vote     (vote),
    .noisy    (noisy)
  );

  rx_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk         (clk),
    .rst         (rst),
    .tick        (os_tick),
    .line        (line),
    .en          (rx_en),
    .vote_stb    (vote_stb),
    .vote        (vote),
    .noisy       (noisy),
    .restart     (restart),
    .active      (active),
    .hunting     (hunting),
    .done        (frame_done),
    .data_out    (f_data),
    .frame_noise (f_noise),
    .stop_bad    (f_stop_bad),
    .is_break    (f_break)
  );

  rx_idle_timer #(.LIMIT(IDLE_TICKS)) u_idle (
    .clk     (clk),
    .rst     (rst),
    .tick    (os_tick),
    .line    (line),
    .hunting (hunting),
    .arm     (frame_done),
    .disarm  (!rx_en),
    .fire    (idle_fire)
  );

  logic rdrf_n, idle_n, ovr_n, noise_n, ferr_n, brk_n;

  always_comb begin
    rdrf_n  = rdrf;
    ovr_n   = ovr;
    noise_n = noise;
    ferr_n  = ferr;
    brk_n   = brk;
    idle_n  = idle;
    if (data_rd) begin
      rdrf_n  = 1'b0;
      ovr_n   = 1'b0;
      noise_n = 1'b0;
      ferr_n  = 1'b0;
      brk_n   = 1'b0;
    end
    if (frame_done) begin
      rdrf_n  = 1'b1;
      noise_n = f_noise;
      ferr_n  = f_stop_bad;
      brk_n   = f_break;
      if (rdrf && !data_rd) ovr_n = 1'b1;
    end
    if (stat_rd)   idle_n = 1'b0;
    if (idle_fire) idle_n = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rdrf    <= 1'b0;
      idle    <= 1'b0;
      ovr     <= 1'b0;
      noise   <= 1'b0;
      ferr    <= 1'b0;
      brk     <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (frame_done) rx_data <= f_data;
      rdrf  <= rdrf_n;
      idle  <= idle_n;
      ovr   <= ovr_n;
      noise <= noise_n;
      ferr  <= ferr_n;
      brk   <= brk_n;
      irq   <= (rie & rdrf_n) | (ilie & idle_n);
    end
  end

  // R3
  rdrf_from_frame_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rdrf) |-> $past(frame_done));

  // R6
  ovr_needs_unread_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(rdrf));

  // R8
  brk_implies_fe_chk: assert property (@(posedge clk) disable iff (rst)
    brk |-> (ferr && (rx_data == '0)));

  // R10
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (($past(rie) && rdrf) || ($past(ilie) && idle)));

  // R7
  idle_from_timer_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(idle) |-> $past(idle_fire));

endmodule

// File: tb/maj_uart_rx_bench.sv
`timescale 1ns/1ps
module maj_uart_rx_bench;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, rx_en = 1'b0, rxd = 1'b1, os_tick = 1'b0;
  logic data_rd = 1'b0, stat_rd = 1'b0, rie = 1'b0, ilie = 1'b0;
  logic [DW-1:0] rx_data;
  logic rdrf, idle, ovr, noise, ferr, brk, irq;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  maj_uart_rx u_maj_uart_rx (
    .clk(clk), .rst(rst), .rx_en(rx_en), .rxd(rxd), .os_tick(os_tick),
    .data_rd(data_rd), .stat_rd(stat_rd), .rie(rie), .ilie(ilie),
    .rx_data(rx_data), .rdrf(rdrf), .idle(idle), .ovr(ovr),
    .noise(noise), .ferr(ferr), .brk(brk), .irq(irq)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic drive_slot(input logic v);
    @(negedge clk);
    rxd = v;
    os_tick = 1'b1;
    @(negedge clk);
    os_tick = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic gap(input int n);
    for (int i = 0; i < n; i++) drive_slot(1'b1);
  endtask

  function automatic logic slot_val(input int b, input int s, input logic [7:0] d,
                                    input logic stopv, input int gbit,
                                    input logic [2:0] gmask, input logic goff);
    logic v;
    if (b == 0)       v = 1'b0;
    else if (b <= DW) v = d[b-1];
    else              v = stopv;
    if (b == gbit) begin
      if (s >= 7 && s <= 9) begin
        if (gmask[s-7]) v = ~v;
      end
      if (goff && s == 3) v = ~v;
    end
    return v;
  endfunction

  task automatic send_frame(input logic [7:0] d, input logic stopv, input int gbit,
                            input logic [2:0] gmask, input logic goff);
    for (int b = 0; b <= DW + 1; b++)
      for (int s = 0; s < 16; s++)
        drive_slot(slot_val(b, s, d, stopv, gbit, gmask, goff));
  endtask

  task automatic expect_frame(input logic [7:0] d, input logic stopv, input int gbit,
                              input logic [2:0] gmask, input logic goff,
                              input logic exp_ovr);
    logic [7:0] ed;
    logic en, ef, a, b2, c, m;
    ed = '0; en = 1'b0; ef = 1'b0;
    for (int b = 0; b <= DW + 1; b++) begin
      a  = slot_val(b, 7, d, stopv, gbit, gmask, goff);
      b2 = slot_val(b, 8, d, stopv, gbit, gmask, goff);
      c  = slot_val(b, 9, d, stopv, gbit, gmask, goff);
      m  = (a & b2) | (a & c) | (b2 & c);
      if (!(a == b2 && b2 == c)) en = 1'b1;
      if (b >= 1 && b <= DW) ed[b-1] = m;
      if (b == DW + 1) ef = !m;
    end
    chk("R3", "rdrf", 32'(rdrf), 32'd1);
    chk("R1", "rx_data", 32'(rx_data), 32'(ed));
    chk("R2", "noise", 32'(noise), 32'(en));
    chk("R8", "ferr", 32'(ferr), 32'(ef));
    chk("R8", "brk", 32'(brk), 32'(ef && ed == 8'h00));
    chk("R6", "ovr", 32'(ovr), 32'(exp_ovr));
  endtask

  task automatic do_read(input logic [7:0] keep);
    @(negedge clk);
    data_rd = 1'b1;
    @(negedge clk);
    data_rd = 1'b0;
    chk("R4", "rdrf after read", 32'(rdrf), 32'd0);
    chk("R4", "err flags after read", 32'({ovr, noise, ferr, brk}), 32'd0);
    chk("R4", "data kept", 32'(rx_data), 32'(keep));
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int seed_init;
    logic unread;
    seed_init = $urandom(32'h5EED_1234);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11", "flags", 32'({rdrf, idle, ovr, noise, ferr, brk, irq}), 32'd0);
    chk("R11", "rx_data", 32'(rx_data), 32'd0);
    rx_en = 1'b1;
    gap(4);

    // R3 clean frame, R10 interrupt
    send_frame(8'hA5, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    expect_frame(8'hA5, 1'b1, -1, 3'b000, 1'b0, 1'b0);
    chk("R3", "lsb first", 32'(rx_data), 32'hA5);
    chk("R10", "irq off with rie low", 32'(irq), 32'd0);
    @(negedge clk); rie = 1'b1;
    @(negedge clk);
    chk("R10", "irq with rie and rdrf", 32'(irq), 32'd1);
    rie = 1'b0;
    @(negedge clk);
    chk("R10", "irq after rie low", 32'(irq), 32'd0);
    do_read(8'hA5);

    // R2 glitch outside the voting window
    send_frame(8'h3C, 1'b1, 4, 3'b000, 1'b1);
    gap(6);
    expect_frame(8'h3C, 1'b1, 4, 3'b000, 1'b1, 1'b0);
    chk("R2", "no noise off window", 32'(noise), 32'd0);
    do_read(8'h3C);

    // R1 single sample flipped
    send_frame(8'h0F, 1'b1, 3, 3'b010, 1'b0);
    gap(6);
    expect_frame(8'h0F, 1'b1, 3, 3'b010, 1'b0, 1'b0);
    chk("R1", "single glitch outvoted", 32'(rx_data), 32'h0F);
    do_read(8'h0F);

    // R1 two samples flipped
    send_frame(8'h0F, 1'b1, 3, 3'b101, 1'b0);
    gap(6);
    expect_frame(8'h0F, 1'b1, 3, 3'b101, 1'b0, 1'b0);
    chk("R1", "double glitch flips bit", 32'(rx_data), 32'h0B);
    do_read(8'h0B);

    // R5 false start
    for (int s = 0; s < 6; s++) drive_slot(1'b0);
    gap(24);
    chk("R5", "false start no rdrf", 32'(rdrf), 32'd0);
    chk("R5", "false start no flags", 32'({noise, ferr, brk}), 32'd0);
    send_frame(8'hC3, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    expect_frame(8'hC3, 1'b1, -1, 3'b000, 1'b0, 1'b0);
    do_read(8'hC3);

    // R6 overrun
    send_frame(8'h11, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    send_frame(8'h22, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    expect_frame(8'h22, 1'b1, -1, 3'b000, 1'b0, 1'b1);
    do_read(8'h22);

    // R8 bad stop bit
    send_frame(8'h5A, 1'b0, -1, 3'b000, 1'b0);
    gap(6);
    expect_frame(8'h5A, 1'b0, -1, 3'b000, 1'b0, 1'b0);
    chk("R8", "framing no break", 32'({ferr, brk}), 32'b10);
    do_read(8'h5A);

    // R8 break
    send_frame(8'h00, 1'b0, -1, 3'b000, 1'b0);
    for (int s = 0; s < 20; s++) drive_slot(1'b0);
    gap(6);
    expect_frame(8'h00, 1'b0, -1, 3'b000, 1'b0, 1'b0);
    chk("R8", "break flags", 32'({ferr, brk}), 32'b11);
    do_read(8'h00);

    // R7 idle line
    send_frame(8'h66, 1'b1, -1, 3'b000, 1'b0);
    do_read(8'h66);
    gap(140);
    chk("R7", "idle not yet", 32'(idle), 32'd0);
    gap(30);
    chk("R7", "idle after char time", 32'(idle), 32'd1);
    @(negedge clk); ilie = 1'b1;
    @(negedge clk);
    chk("R10", "irq on idle", 32'(irq), 32'd1);
    stat_rd = 1'b1;
    @(negedge clk);
    stat_rd = 1'b0;
    chk("R7", "idle cleared by status read", 32'(idle), 32'd0);
    chk("R10", "irq after idle clear", 32'(irq), 32'd0);
    ilie = 1'b0;
    gap(200);
    chk("R7", "idle only once per char", 32'(idle), 32'd0);

    // R9 receiver disabled
    @(negedge clk); rx_en = 1'b0;
    send_frame(8'h77, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    chk("R9", "no rdrf while disabled", 32'(rdrf), 32'd0);
    chk("R9", "data unchanged", 32'(rx_data), 32'h66);
    @(negedge clk); rx_en = 1'b1;
    gap(4);
    send_frame(8'h88, 1'b1, -1, 3'b000, 1'b0);
    gap(6);
    expect_frame(8'h88, 1'b1, -1, 3'b000, 1'b0, 1'b0);
    do_read(8'h88);

    // random frames
    unread = 1'b0;
    for (int n = 0; n < 40; n++) begin
      logic [7:0] d;
      int gbit;
      logic [2:0] gmask;
      logic goff, stopv;
      d     = 8'($urandom);
      gbit  = int'($urandom_range(0, 9));
      gmask = 3'($urandom_range(0, 7));
      if (gbit == 0) gmask = (gmask == 3'd0) ? 3'd0 : (3'b001 << (gmask % 3));
      goff  = 1'($urandom_range(0, 1));
      stopv = ($urandom_range(0, 5) != 0);
      send_frame(d, stopv, gbit, gmask, goff);
      gap(6);
      expect_frame(d, stopv, gbit, gmask, goff, unread);
      chk("R7", "no idle on short gaps", 32'(idle), 32'd0);
      if ($urandom_range(0, 3) != 0) begin
        do_read(rx_data);
        unread = 1'b0;
      end else begin
        unread = 1'b1;
      end
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule